// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block sits between a host and a battery-backed static memory. It guards the memory while the main supply is unreliable. Two digital status inputs come from external comparators. One says the supply is under the deselect level. The other says the supply is under the lower level at which the memory must run from its battery. Both inputs are asynchronous, so each is synchronised and filtered before the block acts on it. With a healthy supply, the active-low chip-enable, output-enable and write-enable pass straight through. The memory then behaves as an ordinary static RAM.

When the supply sags, the block stops new accesses. An access that is already running may finish, but only inside a bounded grace window counted in clock cycles. After that window the memory is locked anyway. While locked, every control output is held inactive and the data-drive enable stays low, so the data pins float. Below the lower level, the power-select output moves the memory onto the battery. When the supply comes back, the block keeps the memory locked for a programmable recovery interval before normal access resumes. The same rule applies after reset.

Top module: `pwrfail_guard`

## Requirements
- R1: While unlocked (`wr_lock`=0), `ce_n_out`, `oe_n_out` and `we_n_out` equal their inputs. `dq_oe` is 1 exactly when chip-enable and output-enable are low, write-enable is high, and the current chip-enable cycle did not start as a write.
- R2: When the supply drops with no access in progress, `wr_lock` goes to 1 within 8 clock cycles of the change on `vlow_async`.
- R3: When the supply drops during an access (chip-enable low and either write-enable or output-enable low), the memory stays unlocked while that access continues. `wr_lock` rises within 3 cycles after the access ends.
- R4: If the access is still running after GRACE_CYC cycles of grace, `wr_lock` is forced to 1. It stays 0 for at least GRACE_CYC cycles after the drop, and it is 1 no later than GRACE_CYC+6 cycles after the drop.
- R5: While `wr_lock` is 1, `ce_n_out`, `oe_n_out` and `we_n_out` are 1 and `dq_oe` is 0, whatever the control inputs do.
- R6: `pwr_bat` goes to 1 within 8 cycles of `vbat_async` going to 1, and back to 0 within 8 cycles of it going to 0. `wr_lock` is 1 whenever `pwr_bat` is 1.
- R7: After `vlow_async` returns to 0, `wr_lock` stays 1 for at least RECOVER_CYC cycles and clears within RECOVER_CYC+20 cycles.
- R8: A supply drop during the recovery interval locks the memory again. The full RECOVER_CYC interval restarts on the next rise.
- R9: If chip-enable and write-enable go low in the same cycle, `dq_oe` stays 0 until chip-enable returns high, even if write-enable rises first.
- R10: During reset and after it, `wr_lock` is 1 and `pwr_bat` is 0. With a good supply, the memory unlocks only after a full recovery interval.
- R11: A supply-low pulse on `vlow_async` lasting one clock cycle has no effect on `wr_lock`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vlow_async | input | 1 | Supply below deselect level, asynchronous |
| vbat_async | input | 1 | Supply below battery switchover level, asynchronous |
| ce_n_in | input | 1 | Host chip-enable, active low |
| oe_n_in | input | 1 | Host output-enable, active low |
| we_n_in | input | 1 | Host write-enable, active low |
| ce_n_out | output | 1 | Gated chip-enable to memory |
| oe_n_out | output | 1 | Gated output-enable to memory |
| we_n_out | output | 1 | Gated write-enable to memory |
| dq_oe | output | 1 | Data pin drive enable, 0 means high impedance |
| wr_lock | output | 1 | Memory is deselected and write protected |
| pwr_bat | output | 1 | 1 selects the battery, 0 the main supply |

## Verification
The hardest case to reach from the ports is an access that outlives the grace window. A supply drop must arrive while a read is held open, the read must stay open past GRACE_CYC cycles, and the bench must confirm that the lock arrived neither early nor late. The bench opens a read, raises the deselect input, and holds the read. It samples `wr_lock` at GRACE_CYC cycles and again at a bound that allows for the synchroniser latency. A second hard case is a drop in the middle of recovery. The bench lets half a recovery interval pass, dips the supply, and then checks that the lock still holds one cycle short of a full interval after the second rise.

// File: rtl/pwrfail_pkg.sv
// Package: shared state encoding for the power-fail guard.
// Assumes: nothing beyond standard SystemVerilog.
package pwrfail_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL  = 3'd0,
        ST_GRACE   = 3'd1,
        ST_PROTECT = 3'd2,
        ST_BATTERY = 3'd3,
        ST_RECOVER = 3'd4
    } pf_state_e;
endpackage

// File: rtl/pwrfail_sync_filt.sv
// Module: two-flop synchroniser per status channel, followed by a stability
// filter. The filtered output changes only after two equal synchronised samples.
// Assumes: the inputs are level signals from comparators. RST_VAL gives the
// assumed level of each channel during reset.
module pwrfail_sync_filt #(
    parameter int          N_CH    = 2,
    parameter logic [1:0]  RST_VAL = 2'b01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] raw_in,
    output logic [N_CH-1:0] filt_out
);
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic meta_q, sync_q, hist_q, filt_q;

        // Purpose: bring the channel into the clock domain and keep one older sample.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
                hist_q <= RST_VAL[g];
            end else begin
                meta_q <= raw_in[g];
                sync_q <= meta_q;
                hist_q <= sync_q;
            end
        end

        // Purpose: accept a new level only when two synchronised samples agree.
        always_ff @(posedge clk) begin
            if (!rst_n)
                filt_q <= RST_VAL[g];
            else if (sync_q == hist_q)
                filt_q <= sync_q;
        end

        assign filt_out[g] = filt_q;
    end
endmodule

// File: rtl/pwrfail_access_mon.sv
// Module: watches the host control strobes. It reports an access in progress
// (active low) and remembers that a chip-enable cycle started as a write.
// Assumes: all strobes are active low and synchronous to clk.
module pwrfail_access_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic acc_busy_n,
    output logic wr_hold
);
    logic ce_n_q;
    logic hold_q;

    // Purpose: an access is live when chip-enable is low and either other strobe is low.
    always_comb acc_busy_n = ~(~ce_n & (~we_n | ~oe_n));

    // Purpose: keep the previous chip-enable level to detect its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ce_n_q <= 1'b1;
        else        ce_n_q <= ce_n;
    end

    // Purpose: flag a cycle whose chip-enable fell together with write-enable low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else if (ce_n)
            hold_q <= 1'b0;
        else if (ce_n_q && !we_n)
            hold_q <= 1'b1;
    end

    assign wr_hold = hold_q;
endmodule

// File: rtl/pwrfail_timer.sv
// Module: loadable down-counter shared by the grace and recovery intervals.
// Assumes: a load has priority over counting. The counter stops at zero.
module pwrfail_timer #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Purpose: load on request, otherwise count down until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwrfail_fsm.sv
// Module: state sequencer for normal, grace, locked, battery and recovery modes.
// Assumes: the low and battery indications are already filtered. The battery
// indication has the highest priority.
module pwrfail_fsm
    import pwrfail_pkg::*;
#(
    parameter int GRACE_CYC   = 16,
    parameter int RECOVER_CYC = 1024,
    parameter int W           = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lo_f,
    input  logic         bat_f,
    input  logic         acc_busy_n,
    input  logic         tmr_zero,
    output pf_state_e    state,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val
);
    localparam logic [W-1:0] GRACE_LD = W'(GRACE_CYC - 1);
    localparam logic [W-1:0] REC_LD   = W'(RECOVER_CYC - 1);

    pf_state_e state_q, state_d;

    // Purpose: choose the next state and any timer reload.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = REC_LD;
        if (bat_f) begin
            state_d = ST_BATTERY;
        end else begin
            unique case (state_q)
                ST_NORMAL: if (lo_f) begin
                    if (!acc_busy_n) begin
                        state_d  = ST_GRACE;
                        tmr_load = 1'b1;
                        tmr_val  = GRACE_LD;
                    end else begin
                        state_d = ST_PROTECT;
                    end
                end
                ST_GRACE:   if (acc_busy_n || tmr_zero) state_d = ST_PROTECT;
                ST_PROTECT: if (!lo_f) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = REC_LD;
                end
                ST_RECOVER: begin
                    if (lo_f)          state_d = ST_PROTECT;
                    else if (tmr_zero) state_d = ST_NORMAL;
                end
                ST_BATTERY: state_d = ST_PROTECT;
                default:    state_d = ST_PROTECT;
            endcase
        end
    end

    // Purpose: state register. Reset starts in the locked state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PROTECT;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/pwrfail_guard.sv
// Module: top of the power-fail guard. It gates the memory strobes, the data
// drive enable and the power source select according to the sequencer state.
// Assumes: host strobes are synchronous to clk. vlow_async and vbat_async come
// from comparators and may change at any time.
module pwrfail_guard
    import pwrfail_pkg::*;
#(
    parameter int GRACE_CYC   = 16,
    parameter int RECOVER_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vlow_async,
    input  logic vbat_async,
    input  logic ce_n_in,
    input  logic oe_n_in,
    input  logic we_n_in,
    output logic ce_n_out,
    output logic oe_n_out,
    output logic we_n_out,
    output logic dq_oe,
    output logic wr_lock,
    output logic pwr_bat
);
    localparam int MAX_CYC = (GRACE_CYC > RECOVER_CYC) ? GRACE_CYC : RECOVER_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);

    logic [1:0]   filt;
    logic         lo_f, bat_f;
    logic         acc_busy_n, wr_hold;
    logic         tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    pf_state_e    state;
    logic         pass;

    pwrfail_sync_filt #(.N_CH(2), .RST_VAL(2'b01)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .raw_in({vbat_async, vlow_async}),
        .filt_out(filt)
    );

    assign lo_f  = filt[0];
    assign bat_f = filt[1];

    pwrfail_access_mon u_acc (
        .clk(clk), .rst_n(rst_n),
        .ce_n(ce_n_in), .oe_n(oe_n_in), .we_n(we_n_in),
        .acc_busy_n(acc_busy_n), .wr_hold(wr_hold)
    );

    pwrfail_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    pwrfail_fsm #(.GRACE_CYC(GRACE_CYC), .RECOVER_CYC(RECOVER_CYC), .W(TMR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .lo_f(lo_f), .bat_f(bat_f),
        .acc_busy_n(acc_busy_n), .tmr_zero(tmr_zero),
        .state(state), .tmr_load(tmr_load), .tmr_val(tmr_val)
    );

    // Purpose: gate strobes and data drive from the sequencer state.
    always_comb begin
        pass     = (state == ST_NORMAL) || (state == ST_GRACE);
        wr_lock  = ~pass;
        pwr_bat  = (state == ST_BATTERY);
        ce_n_out = pass ? ce_n_in : 1'b1;
        oe_n_out = pass ? oe_n_in : 1'b1;
        we_n_out = pass ? we_n_in : 1'b1;
        dq_oe    = pass & ~ce_n_in & ~oe_n_in & we_n_in & ~wr_hold;
    end
endmodule

// File: rtl/pwrfail_guard_chk.sv
// Module: assertion checker bound to pwrfail_guard.
// Assumes: lo_f and bat_f are the filtered supply indications inside the top.
module pwrfail_guard_chk #(
    parameter int GRACE_CYC   = 16,
    parameter int RECOVER_CYC = 1024
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n_in,
    input logic oe_n_in,
    input logic we_n_in,
    input logic ce_n_out,
    input logic oe_n_out,
    input logic we_n_out,
    input logic dq_oe,
    input logic wr_lock,
    input logic pwr_bat,
    input logic lo_f,
    input logic bat_f
);
    logic [31:0] g_cnt, r_cnt;

    // Purpose: count cycles spent unlocked while the supply is low.
    always_ff @(posedge clk) begin
        if (!rst_n || !(lo_f && !wr_lock)) g_cnt <= '0;
        else                               g_cnt <= g_cnt + 1;
    end

    // Purpose: count good-supply cycles since the last low indication.
    always_ff @(posedge clk) begin
        if (!rst_n || lo_f || bat_f)  r_cnt <= '0;
        else if (r_cnt != 32'hFFFF_FFFF) r_cnt <= r_cnt + 1;
    end

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lock |-> (ce_n_out == ce_n_in && oe_n_out == oe_n_in && we_n_out == we_n_in)); // R1
    AST_GRACE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        g_cnt <= 32'(GRACE_CYC + 1)); // R4
    AST_LOCK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lock |-> (ce_n_out && oe_n_out && we_n_out && !dq_oe)); // R5
    AST_BAT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_bat |-> wr_lock); // R6
    AST_RECOVER_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_lock) |-> (r_cnt >= 32'(RECOVER_CYC))); // R7
    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_in |-> !dq_oe); // R9
endmodule

bind pwrfail_guard pwrfail_guard_chk #(.GRACE_CYC(GRACE_CYC), .RECOVER_CYC(RECOVER_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .ce_n_in(ce_n_in), .oe_n_in(oe_n_in), .we_n_in(we_n_in),
    .ce_n_out(ce_n_out), .oe_n_out(oe_n_out), .we_n_out(we_n_out),
    .dq_oe(dq_oe), .wr_lock(wr_lock), .pwr_bat(pwr_bat),
    .lo_f(lo_f), .bat_f(bat_f)
);

// File: tb/tb_pwrfail_guard.sv
module tb_pwrfail_guard;
    localparam int GRACE_CYC   = 16;
    localparam int RECOVER_CYC = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vlow_async = 1'b0, vbat_async = 1'b0;
    logic ce_n_in = 1'b1, oe_n_in = 1'b1, we_n_in = 1'b1;
    logic ce_n_out, oe_n_out, we_n_out, dq_oe, wr_lock, pwr_bat;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    pwrfail_guard #(.GRACE_CYC(GRACE_CYC), .RECOVER_CYC(RECOVER_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .vlow_async(vlow_async), .vbat_async(vbat_async),
        .ce_n_in(ce_n_in), .oe_n_in(oe_n_in), .we_n_in(we_n_in),
        .ce_n_out(ce_n_out), .oe_n_out(oe_n_out), .we_n_out(we_n_out),
        .dq_oe(dq_oe), .wr_lock(wr_lock), .pwr_bat(pwr_bat)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait up to lim cycles for wr_lock to reach val. Returns the cycles waited.
    task automatic wait_lock(input logic val, input int lim, output int waited);
        waited = 0;
        while (wr_lock !== val && waited <= lim) begin
            cyc(1);
            waited++;
        end
    endtask

    task automatic idle_bus();
        ce_n_in = 1'b1; oe_n_in = 1'b1; we_n_in = 1'b1;
    endtask

    task automatic restore_supply(input string req);
        int w;
        vlow_async = 1'b0;
        wait_lock(1'b0, RECOVER_CYC + 20, w);
        chk(wr_lock == 1'b0, req, wr_lock, 0);
    endtask

    task automatic t_reset();
        int w;
        cyc(3);
        chk(wr_lock == 1'b1 && pwr_bat == 1'b0, "R10 reset", {wr_lock, pwr_bat}, 2);
        chk(ce_n_out && oe_n_out && we_n_out && !dq_oe, "R5 reset gates", dq_oe, 0);
        rst_n = 1'b1;
        cyc(RECOVER_CYC - 1);
        chk(wr_lock == 1'b1, "R10 held before full recovery", wr_lock, 1);
        wait_lock(1'b0, 20, w);
        chk(wr_lock == 1'b0, "R10 unlock after recovery", wr_lock, 0);
    endtask

    task automatic t_pass();
        ce_n_in = 0; oe_n_in = 0; we_n_in = 1; cyc(1);
        chk(!ce_n_out && !oe_n_out && we_n_out && dq_oe, "R1 read pass",
            {ce_n_out, oe_n_out, we_n_out, dq_oe}, 3);
        oe_n_in = 1; cyc(1);
        we_n_in = 0; cyc(1);
        chk(!ce_n_out && oe_n_out && !we_n_out && !dq_oe, "R1 write pass",
            {ce_n_out, oe_n_out, we_n_out, dq_oe}, 4'b0100);
        idle_bus(); cyc(1);
        chk(ce_n_out && oe_n_out && we_n_out && !dq_oe, "R1 idle pass",
            {ce_n_out, oe_n_out, we_n_out, dq_oe}, 4'b1110);
    endtask

    task automatic t_same_edge();
        idle_bus(); oe_n_in = 0; cyc(2);
        ce_n_in = 0; we_n_in = 0; cyc(1);
        chk(!dq_oe && !we_n_out, "R9 simultaneous enable", dq_oe, 0);
        we_n_in = 1; cyc(2);
        chk(!dq_oe, "R9 held after write-enable rises", dq_oe, 0);
        ce_n_in = 1; cyc(1);
        ce_n_in = 0; cyc(1);
        chk(dq_oe == 1'b1, "R9 new read cycle drives", dq_oe, 1);
        idle_bus(); cyc(1);
    endtask

    task automatic t_glitch();
        bit stay = 1'b1;
        vlow_async = 1; cyc(1); vlow_async = 0;
        for (int i = 0; i < 12; i++) begin
            cyc(1);
            if (wr_lock) stay = 1'b0;
        end
        chk(stay, "R11 one-cycle glitch ignored", !stay, 0);
    endtask

    task automatic t_drop_idle();
        int w;
        idle_bus();
        vlow_async = 1;
        wait_lock(1'b1, 8, w);
        chk(wr_lock == 1'b1 && w <= 8, "R2 idle drop locks", w, 8);
        restore_supply("R7 recovery after idle drop");
    endtask

    task automatic t_drop_access_end();
        int w;
        ce_n_in = 0; oe_n_in = 0;
        vlow_async = 1;
        cyc(8);
        chk(wr_lock == 1'b0 && ce_n_out == 1'b0, "R3 access continues", wr_lock, 0);
        idle_bus();
        wait_lock(1'b1, 3, w);
        chk(wr_lock == 1'b1 && w <= 3, "R3 lock after access end", w, 3);
        restore_supply("R7 recovery after access drop");
    endtask

    task automatic t_grace_expire();
        int w;
        ce_n_in = 0; oe_n_in = 0;
        vlow_async = 1;
        cyc(GRACE_CYC);
        chk(wr_lock == 1'b0, "R4 not locked before grace ends", wr_lock, 0);
        wait_lock(1'b1, 6, w);
        chk(wr_lock == 1'b1, "R4 forced lock after grace", wr_lock, 1);
        ce_n_in = 0; oe_n_in = 0; we_n_in = 1; cyc(1);
        chk(ce_n_out && oe_n_out && we_n_out && !dq_oe, "R5 read ignored while locked",
            {ce_n_out, oe_n_out, we_n_out, dq_oe}, 4'b1110);
        we_n_in = 0; oe_n_in = 1; cyc(1);
        chk(ce_n_out && oe_n_out && we_n_out && !dq_oe, "R5 write ignored while locked",
            {ce_n_out, oe_n_out, we_n_out, dq_oe}, 4'b1110);
        idle_bus();
    endtask

    task automatic t_battery();
        int w;
        vbat_async = 1;
        w = 0;
        while (!pwr_bat && w <= 8) begin cyc(1); w++; end
        chk(pwr_bat == 1'b1 && w <= 8, "R6 switch to battery", w, 8);
        chk(wr_lock == 1'b1, "R6 locked on battery", wr_lock, 1);
        vbat_async = 0;
        w = 0;
        while (pwr_bat && w <= 8) begin cyc(1); w++; end
        chk(pwr_bat == 1'b0 && w <= 8, "R6 back to main supply", w, 8);
        chk(wr_lock == 1'b1, "R6 still locked below deselect", wr_lock, 1);
    endtask

    task automatic t_recover();
        int w;
        vlow_async = 0;
        cyc(RECOVER_CYC - 1);
        chk(wr_lock == 1'b1, "R7 lock held through recovery", wr_lock, 1);
        wait_lock(1'b0, 20, w);
        chk(wr_lock == 1'b0, "R7 unlock after recovery", wr_lock, 0);
    endtask

    task automatic t_redrop();
        int w;
        vlow_async = 1; cyc(10);
        vlow_async = 0; cyc(RECOVER_CYC / 2);
        vlow_async = 1; cyc(10);
        chk(wr_lock == 1'b1, "R8 locked after drop in recovery", wr_lock, 1);
        vlow_async = 0;
        cyc(RECOVER_CYC - 1);
        chk(wr_lock == 1'b1, "R8 recovery restarted", wr_lock, 1);
        wait_lock(1'b0, 20, w);
        chk(wr_lock == 1'b0, "R8 unlock after restarted recovery", wr_lock, 0);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_same_edge();
        t_glitch();
        t_drop_idle();
        t_drop_access_end();
        t_grace_expire();
        t_battery();
        t_recover();
        t_redrop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule